// File: doc/BRIEF.md
# Synthesizer Control Port

This block is a two-wire serial slave that programs a frequency synthesizer and reports its condition. It watches the clock and data lines, finds START and STOP conditions, and compares each address byte with a fixed five-bit device prefix plus two address bits taken from select pins. Once addressed for writing, it takes data bytes in pairs. The top bit of the first byte of each pair picks the pair's meaning: a 15-bit divider word, or two control bytes holding test mode, reference ratio, pump current, reference output controls and four general output pins.

The divider word is applied in one step. Its high part waits in a staging register until the low byte completes, or until a STOP closes the transfer, so the synthesizer never sees a half-written word. Once addressed for reading, the block shifts out a status byte carrying a sticky power-loss flag and the lock indication. Both lines are sampled with the system clock. The bus master must keep each SCL level for at least four system clocks.

Top module: `synth_ctrl_port`

## Requirements
- R1: An address byte whose upper seven bits equal {5'b11000, addr_sel} is acknowledged by pulling SDA low during the ninth clock, with bit 0 = 0 meaning write and 1 meaning read. Any other address is not acknowledged, and the rest of that transfer is ignored (no acknowledge, no register change) until the next START.
- R2: A write data byte with bit 7 = 0 is divider byte A. Its bits 6:0 become divider bits 14:8, and the next byte gives bits 7:0. The divider output changes only when byte B's eighth bit arrives, and then holds all 15 bits together.
- R3: A write data byte with bit 7 = 1 is control byte A: bits 6:4 give test_mode and bits 3:0 give ref_ratio. The next byte is control byte B: bits 7:6 give pump_sel, bit 5 ref_out_en, bit 4 ref_out_sel, and bits 3:0 port_out. Each control byte takes effect when its eighth bit is received.
- R4: Once a pair is complete, further pairs may follow in the same transfer without a new address, each typed by its own first byte's bit 7.
- R5: A STOP after divider byte A but before byte B loads the staged bits 14:8 into the divider and keeps its previous bits 7:0.
- R6: A STOP in the middle of a byte drops the partial byte. Every register keeps the value given by the last complete byte.
- R7: In read mode the slave sends one status byte MSB first: bit 2 = lock_i, bit 1 = power-loss flag, all other bits 0. SDA is changed only while SCL is low.
- R8: The power-loss flag is 1 after reset and after any supply_lost_i pulse. It is cleared by a STOP that ends a read transfer, and a write transfer leaves it alone.
- R9: After reset: div_word = 0, test_mode = 0, ref_ratio = 0, pump_sel = 0, port_out = 0, ref_out_en = 1, ref_out_sel = 1.
- R10: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Variable address bits |
| lock_i | input | 1 | Synthesizer phase-lock indication |
| supply_lost_i | input | 1 | Pulse sets the power-loss flag |
| div_word | output | 15 | Active divider ratio |
| test_mode | output | 3 | Test mode select |
| ref_ratio | output | 4 | Reference divider ratio select |
| pump_sel | output | 2 | Charge pump current select |
| ref_out_en | output | 1 | Reference output enable |
| ref_out_sel | output | 1 | Reference/comparison output select |
| port_out | output | 4 | General output pins |

## Verification
Assertions check, on every cycle, that SDA drive changes only after a falling SCL or a bus condition, that the slave stays off the bus while it ignores a transfer, that the divider holds while a pair is half written, that the power-loss flag clears only on a read-ending STOP, and that the reference output controls come out of reset set. The scenarios cover the decoding: every possible address byte against one select setting, every select setting, a walking-bit sweep of divider words, mixed pair sequences, STOP at byte boundaries and inside bytes, and status readout across flag and lock changes. These show values that no cycle-local property can predict.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;

    localparam int DIV_W  = 15;
    localparam int BYTE_W = 8;
    localparam int HI_W   = DIV_W - BYTE_W;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_WRITE,
        LK_READ,
        LK_IGNORE
    } link_state_e;

    typedef enum logic {
        PAIR_FREQ,
        PAIR_CTRL
    } pair_kind_e;

    typedef struct packed {
        logic [2:0] test;
        logic [3:0] ratio;
        logic [1:0] pump;
        logic       ref_en;
        logic       ref_sel;
        logic [3:0] ports;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{test: 3'd0, ratio: 4'd0, pump: 2'd0,
                                   ref_en: 1'b1, ref_sel: 1'b1, ports: 4'd0};

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [6:0] a,
                                      input logic [4:0] prefix,
                                      input logic [1:0] sel);
        return a == {prefix, sel};
    endfunction

    function automatic logic [BYTE_W-1:0] make_status(input logic lock,
                                                      input logic lost);
        return {5'b0, lock, lost, 1'b0};
    endfunction

endpackage

// File: rtl/synth_bus_sense.sv
module synth_bus_sense
    import synth_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q, scl_d, sda_q, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            scl_d <= 1'b1;
            sda_q <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= scl_i;
            scl_d <= scl_q;
            sda_q <= sda_i;
            sda_d <= sda_q;
        end
    end

    always_comb begin
        ev.rise  = scl_q & ~scl_d;
        ev.fall  = ~scl_q & scl_d;
        ev.start = scl_q & scl_d & sda_d & ~sda_q;
        ev.stop  = scl_q & scl_d & ~sda_d & sda_q;
        ev.sda   = sda_q;
    end

endmodule

// File: rtl/synth_link.sv
module synth_link
    import synth_ctrl_pkg::*;
#(
    parameter logic [4:0] PREFIX = 5'b11000
)(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [1:0]        addr_sel,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_oe,
    output logic              wr_vld,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              wtxn_open,
    output logic              stop_evt,
    output logic              rd_end
);
    link_state_e       state;
    logic [3:0]        bitn;
    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] rx_next;
    logic [BYTE_W-1:0] tx;
    logic              ack_pend;
    logic              rd_txn;
    logic              nack;

    assign rx_next  = {rx[BYTE_W-2:0], ev.sda};
    assign stop_evt = ev.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= LK_IDLE;
            bitn      <= 4'd0;
            rx        <= '0;
            tx        <= '0;
            sda_oe    <= 1'b0;
            ack_pend  <= 1'b0;
            rd_txn    <= 1'b0;
            nack      <= 1'b0;
            wr_vld    <= 1'b0;
            wr_byte   <= '0;
            wtxn_open <= 1'b0;
            rd_end    <= 1'b0;
        end else begin
            wr_vld    <= 1'b0;
            wtxn_open <= 1'b0;
            rd_end    <= 1'b0;
            if (ev.stop) begin
                state    <= LK_IDLE;
                sda_oe   <= 1'b0;
                ack_pend <= 1'b0;
                rd_end   <= rd_txn;
                rd_txn   <= 1'b0;
            end else if (ev.start) begin
                state    <= LK_ADDR;
                bitn     <= 4'd0;
                sda_oe   <= 1'b0;
                ack_pend <= 1'b0;
                rd_txn   <= 1'b0;
            end else if (state != LK_IDLE && state != LK_IGNORE) begin
                if (ev.rise) begin
                    if (bitn < 4'd8) rx <= rx_next;
                    if (bitn == 4'd7) begin
                        case (state)
                            LK_ADDR: begin
                                if (addr_hit(rx_next[7:1], PREFIX, addr_sel)) begin
                                    ack_pend <= 1'b1;
                                    if (rx_next[0]) begin
                                        state  <= LK_READ;
                                        rd_txn <= 1'b1;
                                    end else begin
                                        state     <= LK_WRITE;
                                        wtxn_open <= 1'b1;
                                    end
                                end else begin
                                    state <= LK_IGNORE;
                                end
                            end
                            LK_WRITE: begin
                                wr_vld   <= 1'b1;
                                wr_byte  <= rx_next;
                                ack_pend <= 1'b1;
                            end
                            default: ack_pend <= 1'b0;
                        endcase
                    end
                    if (bitn == 4'd8) nack <= ev.sda;
                    if (bitn < 4'd9) bitn <= bitn + 4'd1;
                end else if (ev.fall) begin
                    if (bitn == 4'd8) begin
                        sda_oe <= ack_pend;
                    end else if (bitn == 4'd9) begin
                        bitn     <= 4'd0;
                        ack_pend <= 1'b0;
                        if (state == LK_READ && !nack) begin
                            tx     <= status;
                            sda_oe <= ~status[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                            if (state == LK_READ) state <= LK_IGNORE;
                        end
                    end else if (state == LK_READ && bitn != 4'd0) begin
                        sda_oe <= ~tx[BYTE_W-2];
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    AST_OE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!ev.fall && !ev.start && !ev.stop) |=> $stable(sda_oe)); // R7

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == LK_IGNORE) |-> !sda_oe); // R10

endmodule

// File: rtl/synth_regs.sv
module synth_regs
    import synth_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_vld,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              wtxn_open,
    input  logic              stop_evt,
    input  logic              rd_end,
    input  logic              supply_lost,
    input  logic              lock,
    output logic [DIV_W-1:0]  div_word,
    output ctrl_t             ctrl,
    output logic [BYTE_W-1:0] status
);
    logic [HI_W-1:0] stage;
    logic            second;
    pair_kind_e      kind;
    logic            lost;

    assign status = make_status(lock, lost);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_word <= '0;
            stage    <= '0;
            ctrl     <= CTRL_RST;
            second   <= 1'b0;
            kind     <= PAIR_FREQ;
            lost     <= 1'b1;
        end else begin
            if (wtxn_open) second <= 1'b0;
            if (wr_vld) begin
                if (!second) begin
                    second <= 1'b1;
                    if (!wr_byte[BYTE_W-1]) begin
                        kind  <= PAIR_FREQ;
                        stage <= wr_byte[HI_W-1:0];
                    end else begin
                        kind       <= PAIR_CTRL;
                        ctrl.test  <= wr_byte[6:4];
                        ctrl.ratio <= wr_byte[3:0];
                    end
                end else begin
                    second <= 1'b0;
                    if (kind == PAIR_FREQ) begin
                        div_word <= {stage, wr_byte};
                    end else begin
                        ctrl.pump    <= wr_byte[7:6];
                        ctrl.ref_en  <= wr_byte[5];
                        ctrl.ref_sel <= wr_byte[4];
                        ctrl.ports   <= wr_byte[3:0];
                    end
                end
            end
            if (stop_evt) begin
                second <= 1'b0;
                if (second && kind == PAIR_FREQ)
                    div_word <= {stage, div_word[BYTE_W-1:0]};
            end
            if (supply_lost)  lost <= 1'b1;
            else if (rd_end)  lost <= 1'b0;
        end
    end

    AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
        (second && kind == PAIR_FREQ && !wr_vld && !stop_evt) |=> $stable(div_word)); // R2

    AST_LOST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(lost) |-> $past(rd_end)); // R8

    AST_REF_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl.ref_en && ctrl.ref_sel)); // R9

endmodule

// File: rtl/synth_ctrl_port.sv
module synth_ctrl_port
    import synth_ctrl_pkg::*;
#(
    parameter logic [4:0] PREFIX = 5'b11000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       addr_sel,
    input  logic             lock_i,
    input  logic             supply_lost_i,
    output logic [DIV_W-1:0] div_word,
    output logic [2:0]       test_mode,
    output logic [3:0]       ref_ratio,
    output logic [1:0]       pump_sel,
    output logic             ref_out_en,
    output logic             ref_out_sel,
    output logic [3:0]       port_out
);
    bus_ev_t           ev;
    logic [BYTE_W-1:0] status;
    logic              wr_vld;
    logic [BYTE_W-1:0] wr_byte;
    logic              wtxn_open;
    logic              stop_evt;
    logic              rd_end;
    ctrl_t             ctrl;

    synth_bus_sense u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    synth_link #(.PREFIX(PREFIX)) u_link (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .addr_sel  (addr_sel),
        .status    (status),
        .sda_oe    (sda_oe),
        .wr_vld    (wr_vld),
        .wr_byte   (wr_byte),
        .wtxn_open (wtxn_open),
        .stop_evt  (stop_evt),
        .rd_end    (rd_end)
    );

    synth_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_vld      (wr_vld),
        .wr_byte     (wr_byte),
        .wtxn_open   (wtxn_open),
        .stop_evt    (stop_evt),
        .rd_end      (rd_end),
        .supply_lost (supply_lost_i),
        .lock        (lock_i),
        .div_word    (div_word),
        .ctrl        (ctrl),
        .status      (status)
    );

    assign test_mode   = ctrl.test;
    assign ref_ratio   = ctrl.ratio;
    assign pump_sel    = ctrl.pump;
    assign ref_out_en  = ctrl.ref_en;
    assign ref_out_sel = ctrl.ref_sel;
    assign port_out    = ctrl.ports;

endmodule

// File: tb/test_synth_ctrl_port.sv
module test_synth_ctrl_port;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] sel = 2'b10;
    logic lock = 1'b1;
    logic lost_pulse = 1'b0;
    logic sda_line;
    logic sda_oe;
    logic [14:0] div_word;
    logic [2:0] test_mode;
    logic [3:0] ref_ratio;
    logic [1:0] pump_sel;
    logic ref_out_en, ref_out_sel;
    logic [3:0] port_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_ctrl_port i_synth_ctrl_port (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(sel), .lock_i(lock), .supply_lost_i(lost_pulse),
        .div_word(div_word), .test_mode(test_mode), .ref_ratio(ref_ratio),
        .pump_sel(pump_sel), .ref_out_en(ref_out_en), .ref_out_sel(ref_out_sel),
        .port_out(port_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        put_bit(~mack);
    endtask

    function automatic logic [7:0] waddr(input logic [1:0] s);
        return {5'b11000, s, 1'b0};
    endfunction

    task automatic read_status(input logic [7:0] exp, input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        put_byte(waddr(sel) | 8'h01, a);
        chk("R1 read address ack", a, 1'b1);
        get_byte(1'b0, b);
        chk(req, b, exp);
        bus_stop();
    endtask

    task automatic write_pair(input logic [7:0] b0, input logic [7:0] b1);
        logic a;
        bus_start();
        put_byte(waddr(sel), a);
        put_byte(b0, a);
        put_byte(b1, a);
        bus_stop();
    endtask

    initial begin
        repeat (Q * 100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a, a2;
        logic [7:0] b;
        logic [14:0] w, prev;
        logic [6:0] up;

        tick(5);
        rst = 1'b0;
        tick(3);
        // R9 reset values
        chk("R9 div_word", div_word, 15'd0);
        chk("R9 test/ratio/pump/ports", {test_mode, ref_ratio, pump_sel, port_out}, 13'd0);
        chk("R9 ref_out_en/sel", {ref_out_en, ref_out_sel}, 2'b11);

        // R7 R8 status readout: power-loss flag set after reset, lock high
        read_status(8'h06, "R8 status after reset");
        read_status(8'h04, "R8 flag cleared by read STOP");
        lock = 1'b0;
        read_status(8'h00, "R7 lock low");
        lock = 1'b1;
        @(negedge clk); lost_pulse = 1'b1; @(negedge clk); lost_pulse = 1'b0;
        write_pair(8'h80, 8'h30);
        read_status(8'h06, "R8 write keeps flag");
        read_status(8'h04, "R8 cleared again");

        // R1 address sweep over all seven-bit addresses with sel=2'b10
        for (int k = 0; k < 128; k++) begin
            up = k[6:0];
            bus_start();
            put_byte({up, 1'b0}, a);
            put_byte(8'h85, a2);
            bus_stop();
            chk("R1 address ack", a, (up == {5'b11000, sel}));
            chk("R1 ignore after mismatch", a2, (up == {5'b11000, sel}));
        end
        chk("R1 matched ctrl written", ref_ratio, 4'd5);

        // R1 each select value
        for (int s = 0; s < 4; s++) begin
            sel = s[1:0];
            bus_start();
            put_byte(waddr(sel), a);
            chk("R1 select value ack", a, 1'b1);
            bus_stop();
            bus_start();
            put_byte(waddr(sel ^ 2'b01), a);
            chk("R1 wrong select nack", a, 1'b0);
            bus_stop();
        end
        sel = 2'b10;

        // R2 divider walking sweep
        for (int k = 0; k < 15; k++) begin
            w = (15'd1 << k) | 15'(k);
            prev = div_word;
            bus_start();
            put_byte(waddr(sel), a);
            put_byte({1'b0, w[14:8]}, a);
            chk("R2 byte A ack", a, 1'b1);
            chk("R2 held after byte A", div_word, prev);
            put_byte(w[7:0], a);
            chk("R2 applied after byte B", div_word, w);
            bus_stop();
        end

        // R3 R4 control pair then divider pair in one transfer
        bus_start();
        put_byte(waddr(sel), a);
        put_byte(8'hB7, a);
        chk("R3 control A test/ratio", {test_mode, ref_ratio}, {3'd3, 4'd7});
        put_byte(8'h9A, a);
        chk("R3 control B fields", {pump_sel, ref_out_en, ref_out_sel, port_out}, {2'd2, 1'b0, 1'b1, 4'hA});
        put_byte(8'h2B, a);
        put_byte(8'hCD, a);
        chk("R4 second pair divider", div_word, 15'h2BCD);
        put_byte(8'hC1, a);
        put_byte(8'h6F, a);
        chk("R4 third pair control", {test_mode, ref_ratio, pump_sel, ref_out_en, ref_out_sel, port_out},
            {3'd4, 4'd1, 2'd1, 1'b1, 1'b0, 4'hF});
        bus_stop();

        // R5 STOP after byte A commits upper bits only
        bus_start();
        put_byte(waddr(sel), a);
        put_byte(8'h55, a);
        chk("R5 held before STOP", div_word, 15'h2BCD);
        bus_stop();
        tick(2);
        chk("R5 upper committed on STOP", div_word, {7'h55, 8'hCD});

        // R6 STOP inside a byte
        bus_start();
        put_byte(waddr(sel), a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        tick(2);
        chk("R6 partial control A dropped", {test_mode, ref_ratio}, {3'd4, 4'd1});
        bus_start();
        put_byte(waddr(sel), a);
        put_byte(8'hE9, a);
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        bus_stop();
        tick(2);
        chk("R6 control A kept", {test_mode, ref_ratio}, {3'd6, 4'd9});
        chk("R6 control B unchanged", {pump_sel, ref_out_en, ref_out_sel, port_out}, {2'd1, 1'b1, 1'b0, 4'hF});
        chk("R6 divider unchanged", div_word, {7'h55, 8'hCD});

        // R10 master NACK releases the bus
        bus_start();
        put_byte(waddr(sel) | 8'h01, a);
        get_byte(1'b0, b);
        chk("R7 status before NACK test", b, 8'h04);
        get_byte(1'b0, b);
        chk("R10 no drive after NACK", b, 8'hFF);
        bus_stop();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule